// File: doc/BRIEF.md
# PWM Pin Conditioning Stage

This block sits between a set of PWM generators and the device pins. For every channel it takes the generated active-high waveform and a channel enable. It can force the channel low while a fault condition is present, and it can flip the channel's polarity. The result is registered once before it drives the pin, so the pins never see combinational glitches.

A fault condition exists whenever the external fault input or the debug-event input is high. Two six-bit masks, reached through a plain register port with byte offsets, choose which channels are forced low during a fault and which channels are inverted. The force stage comes before the inverter. A channel that is forced and inverted therefore holds its pin high. A disabled channel presents a low level ahead of the inverter, so an inverted idle channel rests high.

The PWM signals and the fault inputs are level signals with no handshake. There is no valid/ready flow at this block's edge and no back-pressure: the pins follow the inputs every clock.

Top module: `pwm_pin_stage`

## Requirements
- R1: After reset both masks read as zero and every pin output is low.
- R2: With no fault condition, a cleared inversion bit and the channel enabled, the pin equals the generated signal one clock after it is sampled.
- R3: A set inversion bit makes the pin the complement of the conditioned signal.
- R4: While the external fault input is high, a channel whose force bit is set drives a low level ahead of the inverter.
- R5: The debug-event input alone creates the same fault condition as the external fault input.
- R6: During a fault condition, a channel whose force bit is clear passes its signal through unchanged.
- R7: A channel that is both forced and inverted outputs high during a fault condition.
- R8: A disabled channel presents low before the inverter, so its pin equals its inversion bit.
- R9: The inversion mask sits at byte offset 0x00 and the force mask at 0x04, with bit n controlling channel n. A read returns the stored six bits in bits 5:0 and zero in bits 31:6.
- R10: A register write takes effect at the next rising clock edge.
- R11: A write to any other offset changes neither mask, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_pwm | input | 6 | Generated PWM signals, active high |
| ch_en | input | 6 | Per-channel enable |
| fault_in | input | 1 | External fault input, active high |
| dbg_evt | input | 1 | Debug event, treated as a fault |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 6 | Write data, one bit per channel |
| reg_rdata | output | 32 | Read data for reg_addr, zero-extended |
| pin_out | output | 6 | Registered pin levels |

## Verification
The bench builds the block with its default parameters: six channels, 8-bit offsets and a 32-bit read bus. With six channels, one vector can carry channels that pass, channels that are forced and channels that are inverted all at the same time. The reserved read bits 31:6 are wide enough to show that zero-extension works. The 8-bit offset space leaves unmapped offsets such as 0x08 free to use for the stray-write and stray-read checks.

// File: rtl/pwm_pin_pkg.sv
package pwm_pin_pkg;
  localparam int unsigned CH_NUM = 6;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned RD_W   = 32;
  localparam logic [7:0]  OFS_INV   = 8'h00;
  localparam logic [7:0]  OFS_FORCE = 8'h04;
endpackage

// File: rtl/pwm_pin_regs.sv
module pwm_pin_regs #(
  parameter int unsigned NCH = pwm_pin_pkg::CH_NUM,
  parameter int unsigned AW  = pwm_pin_pkg::ADDR_W,
  parameter int unsigned DW  = pwm_pin_pkg::RD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [NCH-1:0] wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] inv_mask,
  output logic [NCH-1:0] force_mask
);
  localparam logic [AW-1:0] A_INV   = AW'(pwm_pin_pkg::OFS_INV);
  localparam logic [AW-1:0] A_FORCE = AW'(pwm_pin_pkg::OFS_FORCE);

  logic hit_inv, hit_force;
  assign hit_inv   = (addr == A_INV);
  assign hit_force = (addr == A_FORCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_mask   <= '0;
      force_mask <= '0;
    end else if (wr_en) begin
      if (hit_inv)   inv_mask   <= wdata;
      if (hit_force) force_mask <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_inv)        rdata[NCH-1:0] = inv_mask;
    else if (hit_force) rdata[NCH-1:0] = force_mask;
  end
endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate #(
  parameter int unsigned NCH = pwm_pin_pkg::CH_NUM
) (
  input  logic [NCH-1:0] gen,
  input  logic [NCH-1:0] en,
  input  logic           fault_in,
  input  logic           dbg_evt,
  input  logic [NCH-1:0] force_mask,
  output logic [NCH-1:0] gated
);
  logic fault_act;
  assign fault_act = fault_in | dbg_evt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic live;
    assign live     = gen[c] & en[c];
    assign gated[c] = live & ~(fault_act & force_mask[c]);
  end
endmodule

// File: rtl/pwm_polarity_out.sv
module pwm_polarity_out #(
  parameter int unsigned NCH = pwm_pin_pkg::CH_NUM
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] gated,
  input  logic [NCH-1:0] inv_mask,
  output logic [NCH-1:0] pin
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin[c] <= 1'b0;
      else        pin[c] <= gated[c] ^ inv_mask[c];
    end
  end
endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage #(
  parameter int unsigned NCH = pwm_pin_pkg::CH_NUM,
  parameter int unsigned AW  = pwm_pin_pkg::ADDR_W,
  parameter int unsigned DW  = pwm_pin_pkg::RD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] gen_pwm,
  input  logic [NCH-1:0] ch_en,
  input  logic           fault_in,
  input  logic           dbg_evt,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [NCH-1:0] reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [NCH-1:0] pin_out
);
  logic [NCH-1:0] inv_q;
  logic [NCH-1:0] force_q;
  logic [NCH-1:0] gated;

  pwm_pin_regs #(.NCH(NCH), .AW(AW), .DW(DW)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .inv_mask   (inv_q),
    .force_mask (force_q)
  );

  pwm_fault_gate #(.NCH(NCH)) gate_i (
    .gen        (gen_pwm),
    .en         (ch_en),
    .fault_in   (fault_in),
    .dbg_evt    (dbg_evt),
    .force_mask (force_q),
    .gated      (gated)
  );

  pwm_polarity_out #(.NCH(NCH)) pol_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .gated    (gated),
    .inv_mask (inv_q),
    .pin      (pin_out)
  );
endmodule

// File: rtl/pwm_pin_stage_chk.sv
module pwm_pin_stage_chk #(
  parameter int unsigned NCH = pwm_pin_pkg::CH_NUM,
  parameter int unsigned AW  = pwm_pin_pkg::ADDR_W,
  parameter int unsigned DW  = pwm_pin_pkg::RD_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_en,
  input logic           fault_in,
  input logic           dbg_evt,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [NCH-1:0] reg_wdata,
  input logic [DW-1:0]  reg_rdata,
  input logic [NCH-1:0] pin_out,
  input logic [NCH-1:0] inv_q,
  input logic [NCH-1:0] force_q
);
  localparam logic [AW-1:0] A_INV   = AW'(pwm_pin_pkg::OFS_INV);
  localparam logic [AW-1:0] A_FORCE = AW'(pwm_pin_pkg::OFS_FORCE);

  logic flt;
  logic stray;
  assign flt   = fault_in | dbg_evt;
  assign stray = (reg_addr != A_INV) && (reg_addr != A_FORCE);

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:NCH] == '0);

  // R10
  inv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr && reg_addr == A_INV) |-> inv_q == $past(reg_wdata));

  // R11
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr && stray) |-> $stable(inv_q) && $stable(force_q));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R4
    forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(flt && force_q[c] && !inv_q[c]) |-> !pin_out[c]);
    // R7
    forced_inv_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(flt && force_q[c] && inv_q[c]) |-> pin_out[c]);
    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!ch_en[c]) |-> pin_out[c] == $past(inv_q[c]));
  end
endmodule

bind pwm_pin_stage pwm_pin_stage_chk #(.NCH(NCH), .AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_en     (ch_en),
  .fault_in  (fault_in),
  .dbg_evt   (dbg_evt),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .inv_q     (inv_q),
  .force_q   (force_q)
);

// File: tb/pwm_pin_stage_tb_top.sv
`timescale 1ns/1ps
module pwm_pin_stage_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] gen_pwm = '0;
  logic [5:0] ch_en = '0;
  logic       fault_in = 1'b0;
  logic       dbg_evt = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [5:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0] pin_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [5:0] m_inv = '0;
  logic [5:0] m_frc = '0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  pwm_pin_stage dut_i (
    .clk(clk), .rst_n(rst_n), .gen_pwm(gen_pwm), .ch_en(ch_en),
    .fault_in(fault_in), .dbg_evt(dbg_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_out(pin_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // driver: present one input pattern and queue the pin value it must produce
  task automatic apply(string tag, logic [5:0] g, logic [5:0] e, logic f, logic d);
    logic [5:0] cond;
    @(negedge clk);
    gen_pwm = g; ch_en = e; fault_in = f; dbg_evt = d;
    cond = (g & e) & ~((f | d) ? m_frc : 6'h00);
    exp_q.push_back(cond ^ m_inv);
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [5:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 8'h00) m_inv = v;
    else if (a == 8'h04) m_frc = v;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] expv);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, expv);
  endtask

  // monitor: compare the registered pins one edge after each driven pattern
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {26'b0, pin_out}, {26'b0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pins", {26'b0, pin_out}, 32'h0);
    rd("R1 inv", 8'h00, 32'h0);
    rd("R1 force", 8'h04, 32'h0);
    rst_n = 1'b1;

    // R2: plain pass-through
    apply("R2", 6'h2A, 6'h3F, 0, 0);
    apply("R2", 6'h15, 6'h3F, 0, 0);
    apply("R2", 6'h3F, 6'h3F, 0, 0);
    apply("R2", 6'h00, 6'h3F, 0, 0);

    // R10/R9: write inversion mask, read back zero-extended
    wr(8'h00, 6'h0F);
    rd("R10 inv", 8'h00, 32'h0000_000F);
    apply("R3", 6'h33, 6'h3F, 0, 0);
    apply("R3", 6'h00, 6'h3F, 0, 0);

    // R11: stray offset ignored
    wr(8'h08, 6'h3F);
    rd("R11 inv", 8'h00, 32'h0000_000F);
    rd("R11 force", 8'h04, 32'h0);
    rd("R11 stray rd", 8'h08, 32'h0);

    wr(8'h04, 6'h3C);
    rd("R9 force", 8'h04, 32'h0000_003C);

    // R4/R6/R7 on the external fault input (inv=0F, force=3C)
    apply("R7", 6'h3F, 6'h3F, 1, 0);
    apply("R4", 6'h30, 6'h3F, 1, 0);
    apply("R6", 6'h01, 6'h3F, 1, 0);
    // R5: debug event alone
    apply("R5", 6'h3F, 6'h3F, 0, 1);
    apply("R5", 6'h2A, 6'h3F, 0, 1);
    // fault released
    apply("R2 release", 6'h3F, 6'h3F, 0, 0);

    // R8: disabled channels
    apply("R8", 6'h3F, 6'h00, 0, 0);
    apply("R8", 6'h3F, 6'h30, 0, 0);
    apply("R8", 6'h15, 6'h0C, 1, 1);

    // R3 with full inversion, no fault
    wr(8'h00, 6'h3F);
    wr(8'h04, 6'h00);
    apply("R3", 6'h21, 6'h3F, 0, 0);
    apply("R6", 6'h21, 6'h3F, 1, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule